// File: doc/BRIEF.md
# Multithreaded Microcode Sequencer Arbiter

This block lets four hardware threads share a single microcode ROM. Each thread owns a small sequencer engine. The engine takes a start pulse with an entry address and then walks a routine word by word. Only one ROM read happens per cycle. A fair round-robin arbiter picks which engine gets it, and thread issue priority plays no part in that choice. The command read goes to the instruction buffer of the thread that owns the grant. The outputs are a one-hot issue strobe, the thread index and the command word.

Every thread reports how full its instruction buffer is. A thread whose fill is above half the buffer depth is throttled: it leaves arbitration and issues nothing until the fill falls back to half or below.

Each engine has two named states. `ENG_IDLE` moves to `ENG_RUN` on transition *launch* (start pulse while idle). `ENG_RUN` moves back to `ENG_IDLE` on transition *finish* (a granted read of a word whose end flag is set). `ENG_RUN` stays in `ENG_RUN` on transition *step* (a granted read of a word without the end flag, or no grant). The ROM is a computed table. Its command at address `a` is the low `CMD_W` bits of `a*40503 + 4660`. Its end flag is set when `a[1:0] == 2'b11`.

Top module: `mc_seq_arbiter`

## Requirements
- R1: Each thread's engine runs independently, so all four threads can be inside a routine at the same time and all of them finish.
- R2: A start pulse on an idle thread loads its entry address. The first command for that thread appears on the issue outputs two clock edges after the start pulse is sampled. A start pulse to a thread already running is ignored.
- R3: At most one ROM read is granted per cycle. When at least one thread is eligible (running and not throttled), exactly one is granted.
- R4: An issue is shown by exactly one set bit of `issue_vld`, at the bit of the owning thread. `issue_tid` carries the binary index of that thread. `issue_cmd` equals the ROM command at the address read: the low CMD_W bits of addr*40503+4660.
- R5: Round-robin search starts at the thread after the last granted one and wraps around. After reset the last-granted thread is thread 3, so thread 0 is searched first.
- R6: A thread whose buffer fill is strictly greater than BUF_DEPTH/2 is not issued in the following cycle.
- R7: A fill equal to BUF_DEPTH/2 does not throttle. A throttled thread rejoins arbitration and completes its routine once its fill drops back to BUF_DEPTH/2 or below.
- R8: An engine's pointer advances by one after each granted read. After reading a word whose address has bits [1:0] equal to 2'b11, the engine returns to idle and issues nothing further.
- R9: While reset is asserted, and right after it, `issue_vld` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_req | input | NUM_THR | Per-thread start pulse |
| start_addr | input | NUM_THR*ADDR_W | Per-thread routine entry address, thread i at slice i |
| buf_fill | input | NUM_THR*FILL_W | Per-thread instruction buffer occupancy, thread i at slice i |
| rom_addr | output | ADDR_W | Address read from the ROM this cycle (zero if no grant) |
| issue_vld | output | NUM_THR | One-hot issue strobe per thread |
| issue_cmd | output | CMD_W | Command word being issued |
| issue_tid | output | TID_W | Index of the thread being issued |

## Verification
A start pulse sampled at one edge moves the engine into `ENG_RUN`. The grant happens in the following cycle, and the command is registered at the second edge. The bench therefore checks for no issue one cycle after a start and for the issue strobe two cycles after it. A fill change seen at an edge takes effect on the grant in that same cycle, so the issue that follows is suppressed one edge later. The scoreboard queues the expected commands in grant order before each stimulus is applied. A monitor compares every issue strobe at the falling clock edge, away from the sampling edge. Any strobe with no queued item counts as a mismatch, which also catches issues from idle or throttled threads.

// File: rtl/mc_pkg.sv
package mc_pkg;
    typedef enum logic {
        ENG_IDLE = 1'b0,
        ENG_RUN  = 1'b1
    } eng_state_e;
endpackage

// File: rtl/mc_rom.sv
module mc_rom #(
    parameter int ADDR_W = 6,
    parameter int CMD_W  = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [CMD_W-1:0]  cmd,
    output logic              last
);
    always_comb begin
        cmd  = CMD_W'(32'(addr) * 32'd40503 + 32'd4660);
        last = &addr[1:0];
    end
endmodule

// File: rtl/mc_engine.sv
module mc_engine
    import mc_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              grant,
    input  logic              word_last,
    output logic              running,
    output logic [ADDR_W-1:0] ptr
);
    eng_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ENG_IDLE;
            ptr     <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ENG_IDLE && start)
                ptr <= start_addr;
            else if (state_q == ENG_RUN && grant)
                ptr <= ptr + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENG_IDLE: if (start) state_d = ENG_RUN;
            ENG_RUN:  if (grant && word_last) state_d = ENG_IDLE;
            default:  state_d = ENG_IDLE;
        endcase
    end

    always_comb begin
        running = (state_q == ENG_RUN);
    end
endmodule

// File: rtl/mc_rr_arb.sv
module mc_rr_arb #(
    parameter int NUM_THR = 4,
    localparam int TID_W  = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_THR-1:0] req,
    output logic [NUM_THR-1:0] gnt,
    output logic [TID_W-1:0]   win
);
    logic [TID_W-1:0] last_q;
    logic             found;

    always_comb begin
        gnt   = '0;
        win   = '0;
        found = 1'b0;
        for (int k = 1; k <= NUM_THR; k++) begin
            int idx;
            idx = (int'(last_q) + k) % NUM_THR;
            if (!found && req[idx]) begin
                gnt[idx] = 1'b1;
                win      = TID_W'(idx);
                found    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            last_q <= TID_W'(NUM_THR - 1);
        else if (found)
            last_q <= win;
    end
endmodule

// File: rtl/mc_seq_arbiter.sv
module mc_seq_arbiter #(
    parameter int NUM_THR   = 4,
    parameter int ADDR_W    = 6,
    parameter int CMD_W     = 16,
    parameter int BUF_DEPTH = 8,
    localparam int FILL_W   = $clog2(BUF_DEPTH + 1),
    localparam int TID_W    = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_THR-1:0]        start_req,
    input  logic [NUM_THR*ADDR_W-1:0] start_addr,
    input  logic [NUM_THR*FILL_W-1:0] buf_fill,
    output logic [ADDR_W-1:0]         rom_addr,
    output logic [NUM_THR-1:0]        issue_vld,
    output logic [CMD_W-1:0]          issue_cmd,
    output logic [TID_W-1:0]          issue_tid
);
    localparam logic [FILL_W-1:0] HALF = FILL_W'(BUF_DEPTH / 2);

    logic [NUM_THR-1:0] run_vec;
    logic [NUM_THR-1:0] thr_vec;
    logic [NUM_THR-1:0] elig_vec;
    logic [NUM_THR-1:0] gnt_vec;
    logic [TID_W-1:0]   win_idx;
    logic [ADDR_W-1:0]  ptr_arr [NUM_THR];
    logic [CMD_W-1:0]   rom_cmd;
    logic               rom_last;

    for (genvar i = 0; i < NUM_THR; i++) begin : g_thr
        mc_engine #(.ADDR_W(ADDR_W)) u_eng (
            .clk        (clk),
            .rst_n      (rst_n),
            .start      (start_req[i]),
            .start_addr (start_addr[i*ADDR_W +: ADDR_W]),
            .grant      (gnt_vec[i]),
            .word_last  (rom_last),
            .running    (run_vec[i]),
            .ptr        (ptr_arr[i])
        );
        assign thr_vec[i]  = buf_fill[i*FILL_W +: FILL_W] > HALF;
        assign elig_vec[i] = run_vec[i] & ~thr_vec[i];
    end

    mc_rr_arb #(.NUM_THR(NUM_THR)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (elig_vec),
        .gnt   (gnt_vec),
        .win   (win_idx)
    );

    always_comb begin
        rom_addr = '0;
        for (int i = 0; i < NUM_THR; i++)
            if (gnt_vec[i]) rom_addr = rom_addr | ptr_arr[i];
    end

    mc_rom #(.ADDR_W(ADDR_W), .CMD_W(CMD_W)) u_rom (
        .addr (rom_addr),
        .cmd  (rom_cmd),
        .last (rom_last)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issue_vld <= '0;
            issue_cmd <= '0;
            issue_tid <= '0;
        end else begin
            issue_vld <= gnt_vec;
            issue_cmd <= rom_cmd;
            issue_tid <= win_idx;
        end
    end
endmodule

// File: rtl/mc_seq_checker.sv
module mc_seq_checker #(
    parameter int NUM_THR   = 4,
    parameter int BUF_DEPTH = 8,
    localparam int FILL_W   = $clog2(BUF_DEPTH + 1),
    localparam int TID_W    = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NUM_THR*FILL_W-1:0] buf_fill,
    input logic [NUM_THR-1:0]        issue_vld,
    input logic [TID_W-1:0]          issue_tid,
    input logic [NUM_THR-1:0]        elig,
    input logic [NUM_THR-1:0]        gnt
);
    localparam logic [FILL_W-1:0] HALF = FILL_W'(BUF_DEPTH / 2);

    AST_ONE_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(issue_vld)); // R3

    AST_GNT_IN_ELIG: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~elig) == '0); // R7

    AST_NO_IDLE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        (elig != '0) |-> (gnt != '0)); // R3

    AST_TID_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_vld != '0) |-> issue_vld[issue_tid]); // R4

    AST_RR_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
        ((|$past(gnt)) && ((elig & ~$past(gnt)) != '0)) |-> (gnt != $past(gnt))); // R5

    for (genvar i = 0; i < NUM_THR; i++) begin : g_thr_chk
        AST_THROTTLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (buf_fill[i*FILL_W +: FILL_W] > HALF) |=> !issue_vld[i]); // R6
    end
endmodule

bind mc_seq_arbiter mc_seq_checker #(.NUM_THR(NUM_THR), .BUF_DEPTH(BUF_DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .buf_fill  (buf_fill),
    .issue_vld (issue_vld),
    .issue_tid (issue_tid),
    .elig      (elig_vec),
    .gnt       (gnt_vec)
);

// File: tb/sim_mc_seq_arbiter.sv
module sim_mc_seq_arbiter;
    localparam int NT = 4;
    localparam int AW = 6;
    localparam int CW = 16;
    localparam int BD = 8;
    localparam int FW = $clog2(BD + 1);
    localparam int TW = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NT-1:0]  start_req = '0;
    logic [NT*AW-1:0] start_addr = '0;
    logic [NT*FW-1:0] buf_fill = '0;
    logic [AW-1:0]  rom_addr;
    logic [NT-1:0]  issue_vld;
    logic [CW-1:0]  issue_cmd;
    logic [TW-1:0]  issue_tid;

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct {
        int    tid;
        int    addr;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    mc_seq_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .start_addr(start_addr),
        .buf_fill(buf_fill), .rom_addr(rom_addr), .issue_vld(issue_vld),
        .issue_cmd(issue_cmd), .issue_tid(issue_tid)
    );

    function automatic logic [CW-1:0] exp_cmd(int a);
        return CW'(a * 40503 + 4660);
    endfunction

    task automatic push(int tid, int addr, string tag);
        exp_t e;
        e.tid = tid; e.addr = addr; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic check(bit ok, string tag, string what, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic set_fill(int tid, int v);
        buf_fill[tid*FW +: FW] = FW'(v);
    endtask

    // monitor: compare each issue with the scoreboard head
    always @(negedge clk) begin
        if (rst_n && issue_vld != '0) begin
            if (sb.size() == 0) begin
                check(0, "R8/R6", "unexpected issue vld", int'(issue_vld), 0);
            end else begin
                exp_t e;
                logic [NT-1:0] ev;
                e = sb.pop_front();
                ev = NT'(1) << e.tid;
                check(issue_vld == ev && int'(issue_tid) == e.tid &&
                      issue_cmd == exp_cmd(e.addr), e.tag, "issue vld/tid/cmd",
                      int'({issue_vld, issue_tid, issue_cmd}),
                      int'({ev, TW'(e.tid), exp_cmd(e.addr)}));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(issue_vld == '0, "R9", "issue_vld in reset", int'(issue_vld), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(issue_vld == '0, "R9", "issue_vld after reset", int'(issue_vld), 0);

        // Scenario 1: one thread, latency and routine end (R2, R8)
        for (int a = 8; a < 12; a++) push(2, a, "R8");
        start_addr[2*AW +: AW] = AW'(8);
        start_req[2] = 1'b1;
        @(negedge clk);
        start_req[2] = 1'b0;
        check(issue_vld == '0, "R2", "no issue one cycle after start", int'(issue_vld), 0);
        @(negedge clk);
        check(issue_vld == 4'b0100, "R2", "issue two cycles after start", int'(issue_vld), 4);
        repeat (12) @(negedge clk);

        // Scenario 2: all four threads at once, rotation from last=2 (R1, R5)
        for (int r = 0; r < 4; r++) begin
            push(3, 12 + r, "R5");
            push(0, r,      "R1");
            push(1, 4 + r,  "R1");
            push(2, 8 + r,  "R5");
        end
        for (int t = 0; t < NT; t++) start_addr[t*AW +: AW] = AW'(4 * t);
        start_req = '1;
        @(negedge clk);
        start_req = '0;
        repeat (24) @(negedge clk);

        // Scenario 3: thread 1 throttled above half, later released (R6, R7)
        set_fill(1, BD / 2 + 1);
        for (int a = 16; a < 20; a++) push(0, a, "R6");
        start_addr[0 +: AW] = AW'(16);
        start_addr[AW +: AW] = AW'(32);
        start_req = 4'b0011;
        @(negedge clk);
        start_req = '0;
        repeat (12) @(negedge clk);
        for (int a = 32; a < 36; a++) push(1, a, "R7");
        set_fill(1, BD / 2 - 1);
        repeat (10) @(negedge clk);
        set_fill(1, 0);

        // Scenario 4: fill exactly half does not throttle; alternation (R7, R5)
        set_fill(3, BD / 2);
        for (int r = 0; r < 4; r++) begin
            push(3, 20 + r, "R7");
            push(0, 24 + r, "R5");
        end
        start_addr[3*AW +: AW] = AW'(20);
        start_addr[0 +: AW] = AW'(24);
        start_req = 4'b1001;
        @(negedge clk);
        start_req = '0;
        repeat (12) @(negedge clk);
        set_fill(3, 0);

        // Scenario 5: start to a running engine is ignored (R2)
        for (int a = 28; a < 32; a++) push(2, a, "R2");
        start_addr[2*AW +: AW] = AW'(28);
        start_req[2] = 1'b1;
        @(negedge clk);
        start_addr[2*AW +: AW] = AW'(40);
        @(negedge clk);
        start_req[2] = 1'b0;
        repeat (12) @(negedge clk);

        check(sb.size() == 0, "R1", "items left in scoreboard", sb.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule